// File: doc/BRIEF.md
# Multicycle Instruction Control Sequencer

This block is the control unit of a processor that spends several clock cycles on each instruction. A single state register steps through fetch, decode and operand read, execute or address generation, memory access or result write, and a final load write-back. Every control line to the shared datapath (memory strobes, instruction-register load, PC update, ALU operand and function selects, register-file write controls) is a function of the current state alone. The block is therefore a Moore machine, and its outputs do not glitch when the opcode or the overflow flag change in the middle of a cycle.

The opcode from the instruction register steers the path out of decode and picks load or store after address generation. The supported classes and their lengths are: load in five cycles; store and register-to-register in four; branch-on-equal and jump in three. Two exception paths write the saved-PC register and the cause register, then point the PC at a fixed handler vector. An unknown opcode takes its exception path right after decode. An ALU overflow flagged during register-to-register execution takes the other path in place of the result write.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the next state is fetch. This applies both at start-up and in the middle of an instruction.
- R2: Fetch drives `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `alu_b_sel`=01 and all other outputs 0. The following state is always decode.
- R3: Decode drives `alu_b_sel`=11 and all other outputs 0. It dispatches on `opcode`: 100011 (load) and 101011 (store) go to address generation, 000000 goes to register execute, 000100 goes to branch, and 000010 goes to jump.
- R4: A load takes 5 cycles. Address generation drives `alu_a_sel`=1 and `alu_b_sel`=10. Memory read drives `mem_rd`=1 and `addr_sel`=1. Write-back drives `reg_wr`=1, `wb_sel`=1 and `reg_dst`=0.
- R5: A store takes 4 cycles: address generation, then one cycle with `mem_wr`=1 and `addr_sel`=1, then fetch.
- R6: A register-to-register operation with no overflow takes 4 cycles. Execute drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10. Completion drives `reg_wr`=1, `reg_dst`=1 and `wb_sel`=0.
- R7: A branch takes 3 cycles. Its third cycle drives `alu_a_sel`=1, `alu_op`=01, `pc_wr_cond`=1 and `pc_src`=01.
- R8: A jump takes 3 cycles. Its third cycle drives `pc_wr`=1 and `pc_src`=10.
- R9: Any other opcode at decode leads to one exception cycle and then fetch. That cycle drives `epc_wr`=1, `cause_wr`=1, `cause_val`=0, `pc_wr`=1, `pc_src`=11, `alu_b_sel`=01 and `alu_op`=01, so the ALU forms PC minus 4.
- R10: If `alu_ovf` is 1 during register execute, the next cycle is the exception cycle with `cause_val`=1 instead of the result write. No `reg_wr` is asserted for that instruction.
- R11: `alu_ovf` has no effect in any state other than register execute.
- R12: `opcode` has no effect in any state other than decode and address generation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_ovf | input | 1 | ALU signed-overflow flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by ALU zero |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result register |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Write register: 0 rt field, 1 rd field |
| wb_sel | output | 1 | Write data: 0 ALU result, 1 memory data |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B: 00 reg B, 01 const 4, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU function: 00 add, 01 subtract, 10 from funct field |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 handler vector |
| cause_val | output | 1 | Cause value: 0 undefined opcode, 1 overflow |
| cause_wr | output | 1 | Cause register write |
| epc_wr | output | 1 | Saved-PC register write |

## Verification
Several rules are checked as properties on every clock:
- fetch is always followed by decode;
- decode leads to the right successor for load, undefined and register opcodes;
- a memory read with the data address is followed by a load write-back;
- read and write strobes never overlap;
- an overflow during execute produces a cause-1 exception with no register write;
- each exception cycle loads the handler vector.

Other behaviour can only be shown by the bench's instruction streams, which compare every output against a behavioural model on every cycle. These streams show the exact cycle counts per class and the full control word in each step. They also show that a reset in the middle of an instruction restarts at fetch. Finally, they drive an undefined opcode and a raised overflow flag in every cycle where the block must ignore them, and confirm that neither has any effect there.

// File: rtl/mcfsm_pkg.sv
// Package: shared widths, state encoding, opcode values, select encodings
// and the packed control word used by the multicycle control sequencer.
package mcfsm_pkg;

    localparam int OP_W  = 6;
    localparam int ST_W  = 4;
    localparam int SEL_W = 2;

    // Opcode values recognised at decode
    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_AGEN   = 4'd2,
        ST_MRD    = 4'd3,
        ST_LDWB   = 4'd4,
        ST_MWR    = 4'd5,
        ST_EXEC   = 4'd6,
        ST_RWB    = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9,
        ST_XUNDEF = 4'd10,
        ST_XOVF   = 4'd11
    } state_e;

    typedef enum logic [2:0] {
        CL_LOAD,
        CL_STORE,
        CL_RTYPE,
        CL_BEQ,
        CL_JUMP,
        CL_UNDEF
    } opclass_e;

    typedef enum logic [SEL_W-1:0] {
        BSEL_REG   = 2'b00,
        BSEL_FOUR  = 2'b01,
        BSEL_IMM   = 2'b10,
        BSEL_IMMSH = 2'b11
    } bsel_e;

    typedef enum logic [SEL_W-1:0] {
        AOP_ADD  = 2'b00,
        AOP_SUB  = 2'b01,
        AOP_FUNC = 2'b10
    } aop_e;

    typedef enum logic [SEL_W-1:0] {
        PCS_ALU  = 2'b00,
        PCS_REG  = 2'b01,
        PCS_JMP  = 2'b10,
        PCS_VEC  = 2'b11
    } pcsrc_e;

    typedef struct packed {
        logic   mem_rd;
        logic   mem_wr;
        logic   ir_wr;
        logic   pc_wr;
        logic   pc_wr_cond;
        logic   addr_sel;
        logic   reg_wr;
        logic   reg_dst;
        logic   wb_sel;
        logic   alu_a_sel;
        bsel_e  alu_b_sel;
        aop_e   alu_op;
        pcsrc_e pc_src;
        logic   cause_val;
        logic   cause_wr;
        logic   epc_wr;
    } ctrl_t;

endpackage

// File: rtl/mcfsm_opclass.sv
// Module: mcfsm_opclass
// Maps the raw opcode onto an instruction class. Pure combinational.
// Assumes: any value not listed in the package is an undefined instruction.
module mcfsm_opclass
    import mcfsm_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output opclass_e        op_class
);

    // Classify the opcode
    always_comb begin
        unique case (opcode)
            OPC_LOAD:  op_class = CL_LOAD;
            OPC_STORE: op_class = CL_STORE;
            OPC_RTYPE: op_class = CL_RTYPE;
            OPC_BEQ:   op_class = CL_BEQ;
            OPC_JUMP:  op_class = CL_JUMP;
            default:   op_class = CL_UNDEF;
        endcase
    end

endmodule

// File: rtl/mcfsm_next.sv
// Module: mcfsm_next
// Next-state function of the sequencer. Only decode and address generation
// look at the instruction class, and only register execute looks at overflow.
// Assumes: the opcode is stable from decode through address generation.
module mcfsm_next
    import mcfsm_pkg::*;
(
    input  state_e   cur_st,
    input  opclass_e op_class,
    input  logic     alu_ovf,
    output state_e   nxt_st
);

    // Select the successor state
    always_comb begin
        nxt_st = ST_FETCH;
        unique case (cur_st)
            ST_FETCH:  nxt_st = ST_DECODE;
            ST_DECODE: begin
                unique case (op_class)
                    CL_LOAD, CL_STORE: nxt_st = ST_AGEN;
                    CL_RTYPE:          nxt_st = ST_EXEC;
                    CL_BEQ:            nxt_st = ST_BRANCH;
                    CL_JUMP:           nxt_st = ST_JUMP;
                    default:           nxt_st = ST_XUNDEF;
                endcase
            end
            ST_AGEN:   nxt_st = (op_class == CL_STORE) ? ST_MWR : ST_MRD;
            ST_MRD:    nxt_st = ST_LDWB;
            ST_EXEC:   nxt_st = alu_ovf ? ST_XOVF : ST_RWB;
            ST_LDWB, ST_MWR, ST_RWB, ST_BRANCH, ST_JUMP,
            ST_XUNDEF, ST_XOVF: nxt_st = ST_FETCH;
            default:   nxt_st = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcfsm_ctrl_rom.sv
// Module: mcfsm_ctrl_rom
// Control word per state (Moore outputs). Every field not named for a state
// stays at zero.
// Assumes: unused state codes behave as idle (all zero).
module mcfsm_ctrl_rom
    import mcfsm_pkg::*;
(
    input  state_e cur_st,
    output ctrl_t  ctrl
);

    // Build the control word for the current state
    always_comb begin
        ctrl = '0;
        unique case (cur_st)
            ST_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.ir_wr     = 1'b1;
                ctrl.pc_wr     = 1'b1;
                ctrl.alu_b_sel = BSEL_FOUR;
                ctrl.alu_op    = AOP_ADD;
                ctrl.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctrl.alu_b_sel = BSEL_IMMSH;
                ctrl.alu_op    = AOP_ADD;
            end
            ST_AGEN: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_IMM;
                ctrl.alu_op    = AOP_ADD;
            end
            ST_MRD: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.addr_sel  = 1'b1;
            end
            ST_LDWB: begin
                ctrl.reg_wr    = 1'b1;
                ctrl.wb_sel    = 1'b1;
            end
            ST_MWR: begin
                ctrl.mem_wr    = 1'b1;
                ctrl.addr_sel  = 1'b1;
            end
            ST_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_REG;
                ctrl.alu_op    = AOP_FUNC;
            end
            ST_RWB: begin
                ctrl.reg_wr    = 1'b1;
                ctrl.reg_dst   = 1'b1;
            end
            ST_BRANCH: begin
                ctrl.alu_a_sel  = 1'b1;
                ctrl.alu_b_sel  = BSEL_REG;
                ctrl.alu_op     = AOP_SUB;
                ctrl.pc_wr_cond = 1'b1;
                ctrl.pc_src     = PCS_REG;
            end
            ST_JUMP: begin
                ctrl.pc_wr     = 1'b1;
                ctrl.pc_src    = PCS_JMP;
            end
            ST_XUNDEF, ST_XOVF: begin
                ctrl.alu_b_sel = BSEL_FOUR;
                ctrl.alu_op    = AOP_SUB;
                ctrl.epc_wr    = 1'b1;
                ctrl.cause_wr  = 1'b1;
                ctrl.cause_val = (cur_st == ST_XOVF);
                ctrl.pc_wr     = 1'b1;
                ctrl.pc_src    = PCS_VEC;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
// Module: mc_ctrl_fsm (top)
// Moore control sequencer for a multicycle datapath. It holds the state
// register and combines the opcode classifier, the next-state logic and the
// per-state control word.
// Assumes: opcode comes from the instruction register and is stable after
// fetch; alu_ovf is valid during register execute.
module mc_ctrl_fsm
    import mcfsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    input  logic              alu_ovf,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              ir_wr,
    output logic              pc_wr,
    output logic              pc_wr_cond,
    output logic              addr_sel,
    output logic              reg_wr,
    output logic              reg_dst,
    output logic              wb_sel,
    output logic              alu_a_sel,
    output logic [SEL_W-1:0]  alu_b_sel,
    output logic [SEL_W-1:0]  alu_op,
    output logic [SEL_W-1:0]  pc_src,
    output logic              cause_val,
    output logic              cause_wr,
    output logic              epc_wr
);

    state_e   st_q;
    state_e   st_d;
    opclass_e cls;
    ctrl_t    cw;

    mcfsm_opclass u_cls (
        .opcode   (opcode),
        .op_class (cls)
    );

    mcfsm_next u_next (
        .cur_st   (st_q),
        .op_class (cls),
        .alu_ovf  (alu_ovf),
        .nxt_st   (st_d)
    );

    mcfsm_ctrl_rom u_rom (
        .cur_st (st_q),
        .ctrl   (cw)
    );

    // State register with synchronous active-low reset to fetch
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_FETCH;
        else        st_q <= st_d;
    end

    // Drive the ports from the control word
    always_comb begin
        mem_rd     = cw.mem_rd;
        mem_wr     = cw.mem_wr;
        ir_wr      = cw.ir_wr;
        pc_wr      = cw.pc_wr;
        pc_wr_cond = cw.pc_wr_cond;
        addr_sel   = cw.addr_sel;
        reg_wr     = cw.reg_wr;
        reg_dst    = cw.reg_dst;
        wb_sel     = cw.wb_sel;
        alu_a_sel  = cw.alu_a_sel;
        alu_b_sel  = cw.alu_b_sel;
        alu_op     = cw.alu_op;
        pc_src     = cw.pc_src;
        cause_val  = cw.cause_val;
        cause_wr   = cw.cause_wr;
        epc_wr     = cw.epc_wr;
    end

endmodule

// File: rtl/mcfsm_chk.sv
// Module: mcfsm_chk
// Port-level protocol checks for mc_ctrl_fsm, attached with bind below.
// Assumes: only the top's ports are visible.
module mcfsm_chk
    import mcfsm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [OP_W-1:0]  opcode,
    input logic             alu_ovf,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             ir_wr,
    input logic             pc_wr,
    input logic             pc_wr_cond,
    input logic             addr_sel,
    input logic             reg_wr,
    input logic             reg_dst,
    input logic             wb_sel,
    input logic             alu_a_sel,
    input logic [SEL_W-1:0] alu_b_sel,
    input logic [SEL_W-1:0] alu_op,
    input logic [SEL_W-1:0] pc_src,
    input logic             cause_val,
    input logic             cause_wr,
    input logic             epc_wr
);

    logic in_decode;
    logic op_known;
    assign in_decode = (alu_b_sel == 2'b11);
    assign op_known  = (opcode == OPC_RTYPE) || (opcode == OPC_LOAD) ||
                       (opcode == OPC_STORE) || (opcode == OPC_BEQ) ||
                       (opcode == OPC_JUMP);

    assert_reset_fetch_R1: assert property (@(posedge clk)
        !rst_n |=> (ir_wr && mem_rd && !reg_wr && !mem_wr));

    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> (in_decode && !ir_wr && !mem_rd));

    assert_decode_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_decode && opcode == OPC_LOAD) |=> (alu_a_sel && alu_b_sel == 2'b10));

    assert_decode_rtype_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_decode && opcode == OPC_RTYPE) |=> (alu_op == 2'b10 && alu_a_sel));

    assert_load_writeback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && addr_sel) |=> (reg_wr && wb_sel && !reg_dst));

    assert_mem_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_branch_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |=> ir_wr);

    assert_undef_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_decode && !op_known) |=> (cause_wr && !cause_val));

    assert_exc_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        epc_wr |-> (pc_wr && pc_src == 2'b11 && cause_wr));

    assert_no_overflow_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 2'b10 && alu_ovf) |=> (cause_wr && cause_val && !reg_wr));

endmodule

bind mc_ctrl_fsm mcfsm_chk chk_i (.*);

// File: tb/mc_ctrl_fsm_tb_top.sv
// Bench: instruction streams with a behavioural per-cycle model of the
// expected control word, compared on every clock.
module mc_ctrl_fsm_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'b111111;
    logic       alu_ovf = 1'b1;
    logic       mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, addr_sel;
    logic       reg_wr, reg_dst, wb_sel, alu_a_sel;
    logic [1:0] alu_b_sel, alu_op, pc_src;
    logic       cause_val, cause_wr, epc_wr;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    localparam logic [5:0] GARB = 6'b111111;

    always #4 clk = ~clk;   // 125 MHz

    mc_ctrl_fsm dut_i (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_ovf(alu_ovf),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .pc_wr(pc_wr),
        .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel), .reg_wr(reg_wr),
        .reg_dst(reg_dst), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src),
        .cause_val(cause_val), .cause_wr(cause_wr), .epc_wr(epc_wr)
    );

    // Step names of the model
    localparam int P_IF = 0, P_ID = 1, P_AG = 2, P_RD = 3, P_LW = 4, P_WR = 5,
                   P_EX = 6, P_RW = 7, P_BR = 8, P_JP = 9, P_XU = 10, P_XO = 11;

    // Expected word: {rd,wr,ir,pcw,pcc,asel,rw,rdst,wb,a,b[2],op[2],pcs[2],cv,cw,ew}
    function automatic logic [18:0] expect_word(int p);
        logic rd = 0, wr = 0, ir = 0, pcw = 0, pcc = 0, as = 0, rw = 0;
        logic rdst = 0, wb = 0, a = 0, cv = 0, cw = 0, ew = 0;
        logic [1:0] b = 0, op = 0, ps = 0;
        case (p)
            P_IF: begin rd = 1; ir = 1; pcw = 1; b = 2'b01; end
            P_ID: b = 2'b11;
            P_AG: begin a = 1; b = 2'b10; end
            P_RD: begin rd = 1; as = 1; end
            P_LW: begin rw = 1; wb = 1; end
            P_WR: begin wr = 1; as = 1; end
            P_EX: begin a = 1; op = 2'b10; end
            P_RW: begin rw = 1; rdst = 1; end
            P_BR: begin a = 1; op = 2'b01; pcc = 1; ps = 2'b01; end
            P_JP: begin pcw = 1; ps = 2'b10; end
            default: begin
                b = 2'b01; op = 2'b01; ew = 1; cw = 1; pcw = 1; ps = 2'b11;
                cv = (p == P_XO);
            end
        endcase
        return {rd, wr, ir, pcw, pcc, as, rw, rdst, wb, a, b, op, ps, cv, cw, ew};
    endfunction

    function automatic logic [18:0] actual_word();
        return {mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, addr_sel, reg_wr,
                reg_dst, wb_sel, alu_a_sel, alu_b_sel, alu_op, pc_src,
                cause_val, cause_wr, epc_wr};
    endfunction

    // Called at a falling edge: drive inputs, compare, advance one cycle
    task automatic step(int p, logic [5:0] op_v, logic ovf_v, string tag);
        logic [18:0] e;
        opcode  = op_v;
        alu_ovf = ovf_v;
        #1;
        e = expect_word(p);
        n_cmp++;
        if (actual_word() !== e) begin
            n_bad++;
            $display("FAIL %s step %0d: actual %b expected %b", tag, p, actual_word(), e);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    // Model of one instruction: step list from class, opcode only in decode/agen
    task automatic run_instr(logic [5:0] op_v, logic ovf_v, string tag);
        int seq[$];
        seq = {P_IF, P_ID};
        case (op_v)
            6'b100011: seq = {seq, P_AG, P_RD, P_LW};
            6'b101011: seq = {seq, P_AG, P_WR};
            6'b000000: seq = ovf_v ? {seq, P_EX, P_XO} : {seq, P_EX, P_RW};
            6'b000100: seq = {seq, P_BR};
            6'b000010: seq = {seq, P_JP};
            default:   seq = {seq, P_XU};
        endcase
        foreach (seq[i]) begin
            if (seq[i] == P_ID || seq[i] == P_AG)
                step(seq[i], op_v, 1'b1, {tag, " R3 R11"});
            else if (seq[i] == P_EX)
                step(seq[i], GARB, ovf_v, {tag, " R12"});
            else
                step(seq[i], GARB, 1'b1, {tag, " R11/R12"});
        end
    endtask

    task automatic check_reset_word(string tag);
        #1;
        n_cmp++;
        if (actual_word() !== expect_word(P_IF)) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, actual_word(), expect_word(P_IF));
        end
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected < 5000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_word("R1 reset state");
        rst_n = 1'b1;

        run_instr(6'b100011, 1'b0, "R4 load");
        run_instr(6'b101011, 1'b0, "R5 store");
        run_instr(6'b000000, 1'b0, "R6 rtype");
        run_instr(6'b000000, 1'b1, "R10 rtype overflow");
        run_instr(6'b000100, 1'b0, "R7 branch");
        run_instr(6'b000010, 1'b0, "R8 jump");
        run_instr(6'b001000, 1'b0, "R9 undefined");
        run_instr(6'b111111, 1'b0, "R9 undefined");
        run_instr(6'b100001, 1'b0, "R9 undefined");
        run_instr(6'b000010, 1'b0, "R8 jump");
        run_instr(6'b000010, 1'b0, "R8 jump");
        run_instr(6'b000000, 1'b1, "R10 rtype overflow");
        run_instr(6'b000000, 1'b0, "R6 rtype");

        // Reset in the middle of a load, after address generation
        step(P_IF, GARB, 1'b1, "R2 fetch");
        step(P_ID, 6'b100011, 1'b1, "R3 decode");
        step(P_AG, 6'b100011, 1'b1, "R4 agen");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_reset_word("R1 mid-instruction reset");
        rst_n = 1'b1;

        run_instr(6'b101011, 1'b0, "R5 store");
        run_instr(6'b100011, 1'b0, "R4 load");
        run_instr(6'b000100, 1'b0, "R7 branch");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule